// File: doc/BRIEF.md
# Coarse-Fine Time Interval Digitizer

This block is the digital back end of a two-stage time-to-digital converter. A coarse counter in the reference clock domain is cleared by a time-zero pulse from the beam-crossing reference. After that it counts reference cycles, so it resolves whole reference periods. When a discriminator hit (start) arrives, the block captures the current coarse count. The stop instant is the next edge of the low-jitter reference clock itself.

An analog stretcher widens the residual sub-period interval and presents it as a level pulse. The fine stage counts fast-clock cycles for as long as that pulse is high. The coarse capture crosses into the fast domain through a four-phase handshake with two-flop synchronizers. When the stretched pulse falls, the block joins the coarse count and the fine count into one timestamp and raises a single-cycle valid strobe.

Further flags and counters report the exceptional cases:
- An overflow flag marks a fine count that saturated.
- A no-hit flag marks a reference epoch in which the coarse counter wrapped before any start arrived.
- A dead-time counter counts starts that arrived while a conversion was still in progress.

The time-zero and start inputs are assumed to be already retimed to the reference clock. The stretched pulse is asynchronous to the fast clock.

Top module: `tdc_coarse_fine`

## Requirements
- R1: After reset, valid_o, ovf_o, nohit_o, ts_o and dead_cnt_o are all zero.
- R2: A reference edge that samples t0_i high sets the coarse count to 0, and each later edge adds 1. If start_i is sampled high k edges after the time-zero edge, the captured coarse value is k-1.
- R3: The fine count equals the number of fast-clock cycles during which stretch_i is high, measured after a two-flop synchronizer. The field is FINE_W bits wide.
- R4: ts_o holds the coarse capture in bits [COARSE_W+FINE_W-1:FINE_W] and the fine count in bits [FINE_W-1:0]. It is qualified by valid_o, which is high for exactly one fast cycle after the synchronized stretched pulse falls.
- R5: The fine count saturates at all ones (2^FINE_W-1). ovf_o is set with the word only if stretch_i stays high for more than 2^FINE_W-1 fast cycles. A pulse of exactly 2^FINE_W-1 cycles gives no overflow.
- R6: If the coarse count reaches all ones after a time-zero and no start has been accepted, the block emits one word with nohit_o=1, an all-ones coarse field and a zero fine field. This happens only once per time-zero. Before the first time-zero after reset, no such word appears.
- R7: A start that arrives while a conversion or its handshake is in progress produces no new word. It increments dead_cnt_o by one, modulo 2^DEAD_W.
- R8: A stretched pulse with no pending start capture produces no output word.
- R9: On a word from a normal hit that did not saturate, ovf_o and nohit_o are both 0. The flags are never high while valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference (coarse) clock; its edge is the stop event |
| fast_clk_i | input | 1 | Fast clock for the fine counter |
| rst_ni | input | 1 | Active-low asynchronous reset |
| t0_i | input | 1 | Time-zero pulse, reference domain |
| start_i | input | 1 | Discriminator hit, reference domain |
| stretch_i | input | 1 | Stretched residual pulse, asynchronous |
| ts_o | output | COARSE_W+FINE_W | Combined timestamp, fast domain |
| valid_o | output | 1 | One-cycle strobe for ts_o and flags |
| ovf_o | output | 1 | Fine count saturated |
| nohit_o | output | 1 | Epoch ended without a hit |
| dead_cnt_o | output | DEAD_W | Starts lost to dead time, reference domain |

## Verification
The bench builds the block with COARSE_W=5, FINE_W=6 and DEAD_W=4, and runs the fast clock at five times the reference rate. With a 5-bit coarse counter, the no-hit wrap arrives 32 reference cycles after time-zero. With a 6-bit fine field, the boundary between a saturating pulse and a non-saturating one lies at 63 fast cycles. Both corners can therefore be reached in short runs. Expected words are computed from the edge counts the bench drives: the start offset from time-zero and the stretched-pulse width in fast cycles.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;
  typedef enum logic [1:0] {EV_IDLE, EV_RISE, EV_HOLD, EV_FALL} edge_ev_e;

  function automatic edge_ev_e classify(input logic cur, input logic prev);
    case ({cur, prev})
      2'b10:   return EV_RISE;
      2'b11:   return EV_HOLD;
      2'b01:   return EV_FALL;
      default: return EV_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/tdc_sync.sv
`timescale 1ns/1ps
module tdc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tdc_coarse.sv
`timescale 1ns/1ps
module tdc_coarse #(
  parameter int COARSE_W = 8,
  parameter int DEAD_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                t0_i,
  input  logic                start_i,
  input  logic                ack_i,
  output logic                req_o,
  output logic                nohit_o,
  output logic [COARSE_W-1:0] cap_o,
  output logic [DEAD_W-1:0]   dead_cnt_o
);
  localparam logic [COARSE_W-1:0] CMAX = '1;

  logic [COARSE_W-1:0] cnt_q;
  logic epoch_done_q, busy, accept, nohit_ev;

  assign busy     = req_o | ack_i;
  assign accept   = start_i & ~busy;
  assign nohit_ev = (cnt_q == CMAX) & ~epoch_done_q & ~busy & ~start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      epoch_done_q <= 1'b1;  // no epoch open until the first time-zero
      req_o        <= 1'b0;
      nohit_o      <= 1'b0;
      cap_o        <= '0;
      dead_cnt_o   <= '0;
    end else begin
      cnt_q <= t0_i ? '0 : cnt_q + 1'b1;

      if (accept || nohit_ev) epoch_done_q <= 1'b1;
      else if (t0_i)          epoch_done_q <= 1'b0;

      if (accept || nohit_ev) begin
        req_o   <= 1'b1;
        cap_o   <= cnt_q;
        nohit_o <= nohit_ev;
      end else if (ack_i) begin
        req_o <= 1'b0;
      end

      if (start_i && busy) dead_cnt_o <= dead_cnt_o + 1'b1;
    end
  end

  // R2
  t0_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t0_i |=> (cnt_q == '0));

  // R7
  dead_only_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dead_cnt_o) |-> $past(start_i));

  // R6
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && $past(req_o)) |-> $stable(cap_o));
endmodule

// File: rtl/tdc_fine.sv
`timescale 1ns/1ps
module tdc_fine
  import tdc_pkg::*;
#(
  parameter int COARSE_W = 8,
  parameter int FINE_W   = 12,
  localparam int TS_W    = COARSE_W + FINE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                stretch_i,
  input  logic                req_i,
  input  logic                nohit_i,
  input  logic [COARSE_W-1:0] cap_i,
  output logic                ack_o,
  output logic [TS_W-1:0]     ts_o,
  output logic                valid_o,
  output logic                ovf_o,
  output logic                nohit_o
);
  localparam logic [FINE_W-1:0] FMAX = '1;

  logic        s_sync, s_prev_q, ovf_run_q, pending, emit_hit, emit_nohit;
  logic [FINE_W-1:0] fine_cnt_q;
  edge_ev_e    ev;

  tdc_sync #(.W(1), .STAGES(2)) u_stretch_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (stretch_i),
    .q_o   (s_sync)
  );

  assign ev         = classify(s_sync, s_prev_q);
  assign pending    = req_i & ~ack_o;
  assign emit_hit   = (ev == EV_FALL) & pending & ~nohit_i;
  assign emit_nohit = pending & nohit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_prev_q   <= 1'b0;
      fine_cnt_q <= '0;
      ovf_run_q  <= 1'b0;
      ack_o      <= 1'b0;
      ts_o       <= '0;
      valid_o    <= 1'b0;
      ovf_o      <= 1'b0;
      nohit_o    <= 1'b0;
    end else begin
      s_prev_q <= s_sync;
      case (ev)
        EV_RISE: begin
          fine_cnt_q <= {{(FINE_W-1){1'b0}}, 1'b1};
          ovf_run_q  <= 1'b0;
        end
        EV_HOLD: begin
          if (fine_cnt_q == FMAX) ovf_run_q <= 1'b1;
          else                    fine_cnt_q <= fine_cnt_q + 1'b1;
        end
        default: ;
      endcase

      valid_o <= emit_hit | emit_nohit;
      ovf_o   <= emit_hit & ovf_run_q;
      nohit_o <= emit_nohit;
      if (emit_hit | emit_nohit)
        ts_o <= {cap_i, emit_nohit ? {FINE_W{1'b0}} : fine_cnt_q};

      if (emit_hit || emit_nohit) ack_o <= 1'b1;
      else if (!req_i)            ack_o <= 1'b0;
    end
  end

  // R4
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R9
  flag_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o || nohit_o) |-> valid_o);

  // R5
  fine_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev == EV_HOLD && fine_cnt_q == FMAX) |=> (fine_cnt_q == FMAX && ovf_run_q));
endmodule

// File: rtl/tdc_coarse_fine.sv
`timescale 1ns/1ps
module tdc_coarse_fine #(
  parameter int COARSE_W = 8,
  parameter int FINE_W   = 12,
  parameter int DEAD_W   = 8,
  localparam int TS_W    = COARSE_W + FINE_W
) (
  input  logic              ref_clk_i,
  input  logic              fast_clk_i,
  input  logic              rst_ni,
  input  logic              t0_i,
  input  logic              start_i,
  input  logic              stretch_i,
  output logic [TS_W-1:0]   ts_o,
  output logic              valid_o,
  output logic              ovf_o,
  output logic              nohit_o,
  output logic [DEAD_W-1:0] dead_cnt_o
);
  logic req_ref, req_fast, ack_fast, ack_ref, cap_nohit;
  logic [COARSE_W-1:0] cap;

  tdc_coarse #(.COARSE_W(COARSE_W), .DEAD_W(DEAD_W)) u_coarse (
    .clk_i     (ref_clk_i),
    .rst_ni    (rst_ni),
    .t0_i      (t0_i),
    .start_i   (start_i),
    .ack_i     (ack_ref),
    .req_o     (req_ref),
    .nohit_o   (cap_nohit),
    .cap_o     (cap),
    .dead_cnt_o(dead_cnt_o)
  );

  tdc_sync #(.W(1), .STAGES(2)) u_req_sync (
    .clk_i (fast_clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_ref),
    .q_o   (req_fast)
  );

  tdc_sync #(.W(1), .STAGES(2)) u_ack_sync (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_fast),
    .q_o   (ack_ref)
  );

  // cap and cap_nohit are held stable while the request is up
  tdc_fine #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_fine (
    .clk_i    (fast_clk_i),
    .rst_ni   (rst_ni),
    .stretch_i(stretch_i),
    .req_i    (req_fast),
    .nohit_i  (cap_nohit),
    .cap_i    (cap),
    .ack_o    (ack_fast),
    .ts_o     (ts_o),
    .valid_o  (valid_o),
    .ovf_o    (ovf_o),
    .nohit_o  (nohit_o)
  );
endmodule

// File: tb/tb_tdc_coarse_fine.sv
`timescale 1ns/1ps
module tb_tdc_coarse_fine;
  localparam int REF_PERIOD  = 10;
  localparam int FAST_PERIOD = 2;
  localparam int CW = 5;
  localparam int FW = 6;
  localparam int DW = 4;
  localparam int FMAX = (1 << FW) - 1;
  localparam int CMAX = (1 << CW) - 1;

  logic ref_clk = 0, fast_clk = 0, rst_n = 0;
  logic t0 = 0, start = 0, stretch = 0;
  logic [CW+FW-1:0] ts;
  logic valid, ovf, nohit;
  logic [DW-1:0] dead_cnt;

  int n_chk = 0, n_fail = 0, n_words = 0;
  int last_ts = 0, last_ovf = 0, last_nohit = 0;
  bit done = 0;

  always #(REF_PERIOD/2) ref_clk = ~ref_clk;
  always #(FAST_PERIOD/2) fast_clk = ~fast_clk;

  tdc_coarse_fine #(.COARSE_W(CW), .FINE_W(FW), .DEAD_W(DW)) dut (
    .ref_clk_i(ref_clk), .fast_clk_i(fast_clk), .rst_ni(rst_n),
    .t0_i(t0), .start_i(start), .stretch_i(stretch),
    .ts_o(ts), .valid_o(valid), .ovf_o(ovf), .nohit_o(nohit),
    .dead_cnt_o(dead_cnt)
  );

  always @(negedge fast_clk) begin
    if (valid) begin
      n_words++;
      last_ts    = int'(ts);
      last_ovf   = int'(ovf);
      last_nohit = int'(nohit);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_t0();
    @(negedge ref_clk) t0 = 1;
    @(negedge ref_clk) t0 = 0;
  endtask

  // start sampled k reference edges after the time-zero edge
  task automatic pulse_start(input int k);
    repeat (k-1) @(negedge ref_clk);
    start = 1;
    @(negedge ref_clk) start = 0;
  endtask

  task automatic pulse_stretch(input int n);
    @(negedge fast_clk) stretch = 1;
    repeat (n) @(negedge fast_clk);
    stretch = 0;
    repeat (12) @(negedge ref_clk);
  endtask

  task automatic test_reset();
    chk(valid == 0 && ovf == 0 && nohit == 0, "R1 flags", int'({valid, ovf, nohit}), 0);
    chk(ts == 0, "R1 ts", int'(ts), 0);
    chk(dead_cnt == 0, "R1 dead_cnt", int'(dead_cnt), 0);
    repeat (45) @(negedge ref_clk);
    chk(n_words == 0, "R6 no word before first t0", n_words, 0);
  endtask

  task automatic test_hit(input int k, input int n, input string tag);
    int w0, fexp, eovf;
    w0   = n_words;
    fexp = (n > FMAX) ? FMAX : n;
    eovf = (n > FMAX) ? 1 : 0;
    pulse_t0();
    pulse_start(k);
    repeat (2) @(negedge ref_clk);
    pulse_stretch(n);
    chk(n_words == w0 + 1, {tag, " R4 one word"}, n_words - w0, 1);
    chk(last_ts == (((k-1) << FW) | fexp), {tag, " R2 R3 ts"}, last_ts, ((k-1) << FW) | fexp);
    chk(last_ovf == eovf, {tag, " R5 ovf"}, last_ovf, eovf);
    chk(last_nohit == 0, {tag, " R9 nohit"}, last_nohit, 0);
  endtask

  task automatic test_nohit();
    int w0;
    w0 = n_words;
    pulse_t0();
    repeat (45) @(negedge ref_clk);
    chk(n_words == w0 + 1, "R6 one nohit word", n_words - w0, 1);
    chk(last_nohit == 1, "R6 nohit flag", last_nohit, 1);
    chk(last_ts == (CMAX << FW), "R6 nohit ts", last_ts, CMAX << FW);
    chk(last_ovf == 0, "R6 ovf low", last_ovf, 0);
    repeat (40) @(negedge ref_clk);
    chk(n_words == w0 + 1, "R6 once per epoch", n_words - w0, 1);
  endtask

  task automatic test_dead();
    int w0, d0;
    w0 = n_words;
    d0 = int'(dead_cnt);
    pulse_t0();
    pulse_start(4);
    @(negedge ref_clk) start = 1;
    @(negedge ref_clk) start = 0;
    @(negedge ref_clk);
    chk(int'(dead_cnt) == d0 + 1, "R7 dead_cnt", int'(dead_cnt), d0 + 1);
    pulse_stretch(10);
    chk(n_words == w0 + 1, "R7 single word", n_words - w0, 1);
    chk(last_ts == ((3 << FW) | 10), "R7 first capture kept", last_ts, (3 << FW) | 10);
  endtask

  task automatic test_orphan();
    int w0;
    w0 = n_words;
    pulse_stretch(10);
    chk(n_words == w0, "R8 orphan pulse", n_words - w0, 0);
  endtask

  initial begin
    repeat (3) @(negedge ref_clk);
    rst_n = 1;
    @(negedge ref_clk);
    test_reset();
    test_hit(6, 40, "hit_a");
    test_hit(1, 1, "hit_min");
    test_hit(20, FMAX, "hit_edge");
    test_hit(3, FMAX + 17, "hit_sat");
    test_nohit();
    test_dead();
    test_orphan();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(REF_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule